// File: doc/BRIEF.md
# Pipelined No-Turnaround Burst SRAM

A single-clock synchronous static memory with registered address and control, a parameterized word width split into byte lanes, and a shared data bus presented as separate input, output and output-enable ports. Each active clock edge starts a new cycle: a read, a write, or a deselect. A read and a write place their data in the same slot on the bus, so the two can follow each other on every cycle in either direction with no idle cycles.

A load cycle (advance low) takes a fresh external address. A continue cycle (advance high) keeps the operation type of the last load and steps a 2-bit burst counter that rewrites the two low address bits. The mode input picks linear or interleaved burst order. Three chip selects gate each load. A clock enable freezes the whole block, including the pipeline, the burst state and the output registers. A read that closely follows a write to the same word returns the freshly written bytes through a forwarding path.

Top module: `nowait_burst_sram`

## Requirements
- R1: While reset is asserted and after it, before any operation, `dout_oe` is low and `dout` is zero.
- R2: A read captured at clock edge k (clock enable low at k and at k+1) drives the word on `dout` with `dout_oe` high during the cycle between edges k+1 and k+2.
- R3: For a write captured at edge k, `din` is sampled at edge k+2 and the word is stored; `dout_oe` stays low during that write's data phase.
- R4: Bit i of `lane_wr_n` (active low) guards bits [i*9+8 : i*9] at the default width; a write updates only the lanes whose bit is 0.
- R5: Reads and writes may alternate on consecutive cycles in either direction, and every read returns the correct data with no idle cycle in between.
- R6: A read captured one edge after a write to the same address returns the written lanes from `din` merged with the stored contents of the lanes that were not written.
- R7: With `burst_mode` low, the n-th continue cycle after a load at address A uses A with its two low bits replaced by (A[1:0] + n) mod 4; the upper bits stay.
- R8: With `burst_mode` high, the n-th continue cycle uses A with its two low bits replaced by A[1:0] XOR n.
- R9: A load is a deselect unless `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0. A deselect keeps `dout_oe` low in its data phase, and continue cycles after it are deselects that write nothing.
- R10: While `clk_en_n` is high, all inputs are ignored: `dout` and `dout_oe` hold, no write takes place and the burst counter does not step.
- R11: A continue cycle repeats the operation type of the last load regardless of `wr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| advance | input | 1 | High: continue the burst; low: load a new address |
| wr_n | input | 1 | On a load, low selects write and high selects read |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_mode | input | 1 | Burst order: high interleaved, low linear |
| addr | input | ADDR_W | Word address taken on a load |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data to the bus |
| dout_oe | output | 1 | High while the block drives the bus |

## Verification
The bound properties assume reset is applied once at start-up and that every control input is at a known level at each rising edge. Their read, write and deselect checks also require the clock enable to stay low for the edge after capture, because a freeze stretches the data phase. The bench drives all inputs at falling edges, keeps the selects at a defined level even on continue cycles, and places its freeze windows both inside a data phase and in the middle of a burst, so each property is exercised in the state it was written for.

// File: rtl/nowait_burst_sram.sv
module nowait_burst_sram #(
  parameter int DATA_W = 18,
  parameter int LANES  = 2,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              advance,
  input  logic              wr_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              burst_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_t;

  logic [DATA_W-1:0] mem [DEPTH];
  op_t               b_op, s1_op, s2_op, cur_op;
  logic [ADDR_W-1:0] b_base, s1_addr, s2_addr, cur_addr;
  logic [1:0]        b_cnt, next_cnt, burst_low;
  logic [LANES-1:0]  s1_lanes, s2_lanes;
  logic [DATA_W-1:0] fwd, rd_q;
  logic              selected, hit, oe_q;

  assign selected  = !sel_a_n && sel_b && !sel_c_n;
  assign next_cnt  = b_cnt + 2'd1;
  assign burst_low = burst_mode ? (b_base[1:0] ^ next_cnt) : (b_base[1:0] + next_cnt);
  assign cur_op    = advance ? b_op : (!selected ? OP_IDLE : (wr_n ? OP_RD : OP_WR));
  assign cur_addr  = advance ? {b_base[ADDR_W-1:2], burst_low} : addr;
  assign hit       = (s2_op == OP_WR) && (s2_addr == s1_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign fwd[g*LANE_W +: LANE_W] = (hit && s2_lanes[g]) ? din[g*LANE_W +: LANE_W]
                                                          : mem[s1_addr][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_op     <= OP_IDLE;
      b_base   <= '0;
      b_cnt    <= '0;
      s1_op    <= OP_IDLE;
      s2_op    <= OP_IDLE;
      s1_addr  <= '0;
      s2_addr  <= '0;
      s1_lanes <= '0;
      s2_lanes <= '0;
      rd_q     <= '0;
      oe_q     <= 1'b0;
    end else if (!clk_en_n) begin
      if (!advance) begin
        b_op   <= cur_op;
        b_base <= addr;
        b_cnt  <= '0;
      end else begin
        b_cnt  <= next_cnt;
      end
      s1_op    <= cur_op;
      s1_addr  <= cur_addr;
      s1_lanes <= ~lane_wr_n;
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
      oe_q     <= (s1_op == OP_RD);
      if (s1_op == OP_RD) rd_q <= fwd;
    end
  end

  always_ff @(posedge clk) begin
    if (!clk_en_n && s2_op == OP_WR) begin
      for (int i = 0; i < LANES; i++) begin
        if (s2_lanes[i]) mem[s2_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
      end
    end
  end

  assign dout    = rd_q;
  assign dout_oe = oe_q;
endmodule

// File: rtl/nowait_burst_sram_chk.sv
module nowait_burst_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              advance,
  input logic              wr_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !dout_oe);

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !advance && wr_n && !sel_a_n && sel_b && !sel_c_n) ##1 !clk_en_n |=> dout_oe);

  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !advance && !wr_n && !sel_a_n && sel_b && !sel_c_n) ##1 !clk_en_n |=> !dout_oe);

  // R9
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !advance && !(!sel_a_n && sel_b && !sel_c_n)) ##1 !clk_en_n |=> !dout_oe);

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(dout) && $stable(dout_oe));
endmodule

bind nowait_burst_sram nowait_burst_sram_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .advance(advance), .wr_n(wr_n),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/nowait_burst_sram_test.sv
module nowait_burst_sram_test;
  localparam int ID = 0, RD = 1, WR = 2;
  localparam logic [2:0] SEL = 3'b010;
  localparam logic [2:0] NOSEL = 3'b110;

  logic clk = 1'b0, rst_n = 1'b0, clk_en_n = 1'b0, advance = 1'b0, wr_n = 1'b1;
  logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1, burst_mode = 1'b0;
  logic [4:0]  addr = '0;
  logic [1:0]  lane_wr_n = 2'b11;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic        dout_oe;

  int tests = 0, fails = 0;
  logic [17:0] mm [32];
  int bop = ID;
  logic [4:0] bbase = '0;
  logic [1:0] bcnt = '0;
  int ha_op = ID, hb_op = ID;
  logic [4:0] ha_addr = '0, hb_addr = '0;
  logic [1:0] ha_lanes = '0, hb_lanes = '0;
  logic [17:0] ha_data = '0, hb_data = '0;
  string ha_tag = "R1", hb_tag = "R1";

  nowait_burst_sram uut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .advance(advance), .wr_n(wr_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .burst_mode(burst_mode),
    .addr(addr), .lane_wr_n(lane_wr_n), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  always #10 clk = ~clk;

  function automatic logic [17:0] pat(input int a);
    return 18'h0A000 ^ 18'(a * 291);
  endfunction

  task automatic check(input string what, input string tag, input logic [17:0] act, input logic [17:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic ce_n, input logic adv, input logic wrn, input logic [2:0] selv,
                      input logic [1:0] lanes_n, input logic [4:0] a, input logic md,
                      input logic [17:0] wd, input string tag);
    logic [1:0] low;
    logic [4:0] na;
    @(negedge clk);
    check("oe", hb_tag, {17'd0, dout_oe}, {17'd0, hb_op == RD});
    if (hb_op == RD) check("data", hb_tag, dout, mm[hb_addr]);
    din = (hb_op == WR) ? hb_data : 18'h15A5A;
    clk_en_n = ce_n; advance = adv; wr_n = wrn; {sel_a_n, sel_b, sel_c_n} = selv;
    lane_wr_n = lanes_n; addr = a; burst_mode = md;
    if (!ce_n) begin
      if (hb_op == WR) begin
        if (hb_lanes[0]) mm[hb_addr][8:0]  = hb_data[8:0];
        if (hb_lanes[1]) mm[hb_addr][17:9] = hb_data[17:9];
      end
      if (!adv) begin
        bop = (selv == SEL) ? (wrn ? RD : WR) : ID;
        bbase = a; bcnt = 2'd0; na = a;
      end else begin
        bcnt = bcnt + 2'd1;
        low = md ? (bbase[1:0] ^ bcnt) : (bbase[1:0] + bcnt);
        na = {bbase[4:2], low};
      end
      hb_op = ha_op; hb_addr = ha_addr; hb_lanes = ha_lanes; hb_data = ha_data; hb_tag = ha_tag;
      ha_op = bop; ha_addr = na; ha_lanes = ~lanes_n; ha_data = wd; ha_tag = tag;
    end
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    step(0, 0, 1, SEL, 2'b11, a, 0, 18'd0, tag);
  endtask
  task automatic wr(input logic [4:0] a, input logic [1:0] ln, input logic [17:0] d, input string tag);
    step(0, 0, 0, SEL, ln, a, 0, d, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 1, NOSEL, 2'b11, 5'd0, 0, 18'd0, tag);
  endtask
  task automatic flush(input string tag);
    idle(tag); idle(tag); idle(tag);
  endtask

  task automatic t_reset;
    check("oe in reset", "R1", {17'd0, dout_oe}, 18'd0);
    check("dout in reset", "R1", dout, 18'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("oe after reset", "R1", {17'd0, dout_oe}, 18'd0);
    check("dout after reset", "R1", dout, 18'd0);
  endtask

  task automatic t_fill;
    for (int b = 0; b < 32; b += 4) begin
      step(0, 0, 0, SEL, 2'b00, 5'(b), 0, pat(b), "R11");
      for (int k = 1; k < 4; k++) step(0, 1, 1, NOSEL, 2'b00, 5'd0, 0, pat(b + k), "R11");
    end
    flush("R11");
  endtask

  task automatic t_readback;
    rd(0, "R2"); rd(7, "R2"); rd(13, "R2"); rd(31, "R2"); rd(22, "R2");
    flush("R2");
  endtask

  task automatic t_write_new;
    wr(9, 2'b00, 18'h3C3C3, "R3"); idle("R3"); idle("R3");
    rd(9, "R3"); rd(8, "R3");
    flush("R3");
  endtask

  task automatic t_lanes;
    wr(12, 2'b10, 18'h3FFFF, "R4");
    wr(20, 2'b01, 18'h00000, "R4");
    wr(21, 2'b11, 18'h12345, "R4");
    idle("R4"); idle("R4");
    rd(12, "R4"); rd(20, "R4"); rd(21, "R4");
    flush("R4");
  endtask

  task automatic t_alternate;
    wr(3, 2'b00, 18'h01111, "R5"); rd(4, "R5");
    wr(5, 2'b00, 18'h02222, "R5"); rd(6, "R5");
    wr(4, 2'b00, 18'h03333, "R5"); rd(3, "R5");
    rd(5, "R5"); wr(6, 2'b00, 18'h04444, "R5"); rd(4, "R5"); rd(6, "R5");
    flush("R5");
  endtask

  task automatic t_forward;
    wr(10, 2'b00, 18'h2ABCD, "R6"); rd(10, "R6");
    wr(11, 2'b01, 18'h3F0F0, "R6"); rd(11, "R6");
    wr(14, 2'b10, 18'h155AA, "R6"); rd(14, "R6");
    rd(10, "R6");
    flush("R6");
  endtask

  task automatic t_linear;
    step(0, 0, 1, SEL, 2'b11, 5'd6, 0, 18'd0, "R7");
    for (int k = 1; k < 4; k++) step(0, 1, 0, NOSEL, 2'b00, 5'd0, 0, 18'd0, "R7");
    step(0, 0, 1, SEL, 2'b11, 5'd29, 0, 18'd0, "R7");
    for (int k = 1; k < 4; k++) step(0, 1, 1, SEL, 2'b11, 5'd0, 0, 18'd0, "R7");
    flush("R7");
  endtask

  task automatic t_interleaved;
    step(0, 0, 1, SEL, 2'b11, 5'd17, 1, 18'd0, "R8");
    for (int k = 1; k < 4; k++) step(0, 1, 1, SEL, 2'b11, 5'd0, 1, 18'd0, "R8");
    step(0, 0, 0, SEL, 2'b00, 5'd26, 1, 18'h0C001, "R8");
    for (int k = 1; k < 4; k++) step(0, 1, 1, SEL, 2'b00, 5'd0, 1, 18'(18'h0C001 + k), "R8");
    idle("R8"); idle("R8");
    rd(24, "R8"); rd(25, "R8"); rd(26, "R8"); rd(27, "R8");
    flush("R8");
  endtask

  task automatic t_deselect;
    step(0, 0, 0, 3'b110, 2'b00, 5'd0, 0, 18'h3EEEE, "R9");
    step(0, 1, 0, 3'b010, 2'b00, 5'd0, 0, 18'h3EEEE, "R9");
    step(0, 0, 0, 3'b000, 2'b00, 5'd1, 0, 18'h3DDDD, "R9");
    step(0, 0, 0, 3'b011, 2'b00, 5'd2, 0, 18'h3CCCC, "R9");
    step(0, 1, 0, SEL, 2'b00, 5'd0, 0, 18'h3BBBB, "R9");
    step(0, 0, 1, 3'b111, 2'b11, 5'd5, 0, 18'd0, "R9");
    idle("R9");
    rd(0, "R9"); rd(1, "R9"); rd(2, "R9"); rd(3, "R9");
    flush("R9");
  endtask

  task automatic t_freeze;
    rd(7, "R10");
    step(1, 0, 0, SEL, 2'b00, 5'd8, 0, 18'h11111, "R10");
    step(1, 0, 0, SEL, 2'b00, 5'd8, 0, 18'h11111, "R10");
    rd(13, "R10");
    step(1, 1, 0, SEL, 2'b00, 5'd8, 0, 18'h22222, "R10");
    step(1, 1, 0, SEL, 2'b00, 5'd8, 0, 18'h22222, "R10");
    step(1, 1, 0, SEL, 2'b00, 5'd8, 0, 18'h22222, "R10");
    wr(15, 2'b00, 18'h26262, "R10");
    step(1, 0, 1, SEL, 2'b11, 5'd9, 0, 18'd0, "R10");
    rd(15, "R10");
    step(1, 0, 1, SEL, 2'b11, 5'd9, 0, 18'd0, "R10");
    idle("R10");
    step(0, 0, 1, SEL, 2'b11, 5'd18, 0, 18'd0, "R10");
    step(0, 1, 1, SEL, 2'b11, 5'd0, 0, 18'd0, "R10");
    step(1, 1, 1, SEL, 2'b11, 5'd0, 0, 18'd0, "R10");
    step(1, 1, 1, SEL, 2'b11, 5'd0, 0, 18'd0, "R10");
    step(0, 1, 1, SEL, 2'b11, 5'd0, 0, 18'd0, "R10");
    step(0, 1, 1, SEL, 2'b11, 5'd0, 0, 18'd0, "R10");
    flush("R10");
    rd(8, "R10");
    flush("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mm[i] = 18'd0;
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_readback();
    t_write_new();
    t_lanes();
    t_alternate();
    t_forward();
    t_linear();
    t_interleaved();
    t_deselect();
    t_freeze();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule